// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin Pair Control Register

This block is a single memory-mapped control word that lets software drive a two-wire serial bus by toggling pins directly. One pin carries the bus clock and the other carries the bus data. Each pin is open-drain. To release a pin, software makes it an input and the external pull-up raises the line. To pull a pin low, software makes it an output with a stored value of zero.

Each pin has a direction field and a value field, and each of those fields has its own write-mask bit in the same word. One write can therefore change the direction of one pin alone, or its value alone, and no read-modify-write is needed. Each pin also has a pull-up-disable bit. These bits are plain read/write, so software can read them back and write them again unchanged. The level seen at each pad goes through a two-flop synchroniser and appears as a read-only input bit.

Each pin has its own 8-bit lane. Pin 0 (the clock pin) uses bits [7:0] and pin 1 (the data pin) uses bits [15:8]. Within a lane the bits are:

| Bit | Field | Access | Meaning |
|-----|-------|--------|---------|
| 0 | dir | read/write | 1 = output, 0 = input |
| 1 | dir mask | write-only | write enable for dir |
| 2 | val | read/write | stored output value |
| 3 | val mask | write-only | write enable for val |
| 4 | in | read-only | synchronised pad level |
| 5 | pull-up disable | read/write | plain read/write bit |
| 6, 7 | unused | — | read as 0 |

Top module: `odpin_pair_reg`

## Requirements
- R1: After reset, both dir bits are 0, both val bits are 0, both pull-up-disable bits are 0, both synchroniser stages are 0, and rd_data is 0.
- R2: On a write, a pin's dir bit (lane bit 0) takes the written value only when its dir mask (lane bit 1) is 1 in the same write data. Otherwise the dir bit keeps its old value.
- R3: On a write, a pin's val bit (lane bit 2) takes the written value only when its val mask (lane bit 3) is 1 in the same write data. Otherwise the val bit keeps its old value.
- R4: Every write loads the pull-up-disable bit (lane bit 5) of each pin from the write data. The bit reads back as written.
- R5: The mask bits (lane bits 1 and 3) and the unused lane bits 6 and 7 always read as 0.
- R6: pad_oe[i] is 1 exactly when pin i's dir bit is 1. pad_out[i] equals pin i's stored val bit.
- R7: Lane bit 4 shows pad_in[i] after two rising clock edges. A value written to bit 4 has no effect.
- R8: A write whose mask bits are set only in one lane leaves the dir and val bits of the other pin unchanged.
- R9: Writing dir=0 with the dir mask set and the val mask clear releases the pin: pad_oe goes to 0 and the stored val is kept. Writing dir=1, val=0 with both masks set pulls the line low: pad_oe is 1 and pad_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: control fields and mask bits |
| rd_data | output | 16 | Read-back of the control word |
| pad_in | input | 2 | Pad levels; bit 0 is the clock pin, bit 1 is the data pin |
| pad_oe | output | 2 | Pad output enables |
| pad_out | output | 2 | Pad output values |

## Verification
The bench targets writes whose mask bits disagree with the data bits. A design that ignored a mask would move a pin's direction or value when it should have held it. A write with masks in only one lane would expose any cross-talk between the two pins. The bench also checks that mask bits and unused bits read back as 0, since a design that stored the masks would return them on a read. It also checks that the input bit changes exactly on the second clock edge after the pad changes, not on the first and not on the third. A correct design holds the stored value while a pin is released, so the bench checks that the old value comes back when the pin is driven again.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned B_DIR    = 0;
    localparam int unsigned B_DIR_M  = 1;
    localparam int unsigned B_VAL    = 2;
    localparam int unsigned B_VAL_M  = 3;
    localparam int unsigned B_IN     = 4;
    localparam int unsigned B_PUD    = 5;

    typedef struct packed {
        logic dir;
        logic val;
        logic pud;
    } lane_state_t;
endpackage

// File: rtl/odpin_in_sync.sv
module odpin_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_lvl,
    output logic sync_lvl
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic [1:0] age;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pad_lvl;
        st_d.s2 = st_q.s1;
        if (st_q.age != 2'd2) st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_lvl = st_q.s2;

    a_r7_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == 2'd2) |-> (sync_lvl == $past(pad_lvl, 2)));
endmodule

// File: rtl/odpin_lane.sv
module odpin_lane
    import odpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane_wdata,
    input  logic              in_lvl,
    output logic [LANE_W-1:0] lane_rdata,
    output logic              oe,
    output logic              out_val
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (lane_wdata[B_DIR_M]) st_d.dir = lane_wdata[B_DIR];
            if (lane_wdata[B_VAL_M]) st_d.val = lane_wdata[B_VAL];
            st_d.pud = lane_wdata[B_PUD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lane_rdata        = '0;
        lane_rdata[B_DIR] = st_q.dir;
        lane_rdata[B_VAL] = st_q.val;
        lane_rdata[B_IN]  = in_lvl;
        lane_rdata[B_PUD] = st_q.pud;
    end

    assign oe      = st_q.dir;
    assign out_val = st_q.val;

    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && lane_wdata[B_DIR_M]) |=> $stable(oe));
    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_wdata[B_DIR_M]) |=> (oe == $past(lane_wdata[B_DIR])));
    a_r3_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && lane_wdata[B_VAL_M]) |=> $stable(out_val));
    a_r4_pud_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lane_rdata[B_PUD] == $past(lane_wdata[B_PUD])));
endmodule

// File: rtl/odpin_pair_reg.sv
module odpin_pair_reg
    import odpin_pkg::*;
#(
    parameter int unsigned NUM_PINS = 2,
    localparam int unsigned WORD_W = NUM_PINS * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic in_lvl;

        odpin_in_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_lvl  (pad_in[i]),
            .sync_lvl (in_lvl)
        );

        odpin_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .lane_wdata (wr_data[i*LANE_W +: LANE_W]),
            .in_lvl     (in_lvl),
            .lane_rdata (rd_data[i*LANE_W +: LANE_W]),
            .oe         (pad_oe[i]),
            .out_val    (pad_out[i])
        );

        a_r5_masks_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[i*LANE_W + B_DIR_M] == 1'b0) && (rd_data[i*LANE_W + B_VAL_M] == 1'b0));
    end
endmodule

// File: tb/sim_odpin_pair_reg.sv
module sim_odpin_pair_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  pad_in = 2'b00;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;

    int n_checks = 0;
    int n_fail = 0;

    logic [1:0] m_dir = '0, m_val = '0, m_pud = '0;

    always #4 clk = ~clk;

    odpin_pair_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [15:0] exp_rd(input logic [1:0] pin_lvl);
        logic [15:0] r = '0;
        for (int i = 0; i < 2; i++) begin
            r[i*8+0] = m_dir[i];
            r[i*8+2] = m_val[i];
            r[i*8+4] = pin_lvl[i];
            r[i*8+5] = m_pud[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] d);
        for (int i = 0; i < 2; i++) begin
            if (d[i*8+1]) m_dir[i] = d[i*8+0];
            if (d[i*8+3]) m_val[i] = d[i*8+2];
            m_pud[i] = d[i*8+5];
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = $urandom;
        model_write(d);
    endtask

    task automatic check_all(input string req);
        chk(req, {16'h0, rd_data}, {16'h0, exp_rd(pad_in)});
        chk(req, {30'h0, pad_oe}, {30'h0, m_dir});
        chk(req, {30'h0, pad_out}, {30'h0, m_val});
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        pad_in = 2'b11;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", {16'h0, rd_data}, 32'h0);
        chk("R1 pad_oe", {30'h0, pad_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check_all("R7 sync after reset");

        // R9 pull low, then release
        do_write(16'h000F & 16'h000B);              // clk: dir=1 mask, val=0 mask
        check_all("R9 pull low");
        chk("R9 oe low", {31'h0, pad_oe[0]}, 32'h1);
        chk("R9 out low", {31'h0, pad_out[0]}, 32'h0);
        do_write(16'h0006);                          // val=1 data, val mask clear; dir=0 mask
        check_all("R9 release keeps val");
        chk("R9 released", {31'h0, pad_oe[0]}, 32'h0);

        // R2/R3 data without mask ignored
        do_write(16'h0505);
        check_all("R2 R3 no mask hold");
        // R3 value load with mask
        do_write(16'h0C0C);
        check_all("R3 val load");
        // R8 only data-pin lane masks
        do_write(16'h0B00 | 16'h0005);
        check_all("R8 lane isolation");
        // R4 pud plain
        do_write(16'h2020);
        check_all("R4 pud set");
        do_write(16'h0000);
        check_all("R4 pud clear");
        // R5 masks and unused bits read 0 after all-ones write
        do_write(16'hFFFF);
        check_all("R5 masks readback");
        chk("R5 unused", {16'h0, rd_data & 16'hCACA}, 32'h0);

        // R7 two-edge latency, write to input bit ignored
        do_write(16'h1010);
        check_all("R7 in bit not writable");
        pad_in = 2'b01;
        @(negedge clk);
        chk("R7 after one edge", {31'h0, rd_data[12]}, 32'h1);
        chk("R7 after one edge clk", {31'h0, rd_data[4]}, 32'h1);
        @(negedge clk);
        chk("R7 after two edges", {30'h0, rd_data[12], rd_data[4]}, 32'h1);

        // R6 random masked writes
        for (int k = 0; k < 300; k++) begin
            do_write(16'($urandom));
            check_all("R6 R2 R3 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule